// File: doc/BRIEF.md
# Serial Flash Status Register and Block Write Guard

This block keeps the eight-bit status byte of a serial NOR flash and decides, for every program or erase that the command decoder wants to start, whether it may go ahead. The command decoder hands it one-cycle requests: set or clear the write-enable latch, write the status byte, and start a program or erase at a given 64 KB block. The block samples the active-low write-protect pin. It answers each program or erase request with a one-cycle grant or deny. While a granted operation runs, the block holds the write-in-progress bit until the executor reports completion.

The protected region always grows downward from the highest block. Three level bits in the status byte select it: no blocks, the top one, the top two, the top four, the top eight, or the whole array. A status write that sets the level bits and the lock bit is not instant. It keeps write-in-progress high for a fixed number of cycles and updates the byte only when that interval ends. The lock bit, together with the write-protect pin held low, freezes the status byte. The status byte is driven out continuously, so the serial front end can stream it for as long as the host keeps polling.

Top module: `fsr_status_guard`

## Requirements
- R1: After reset the status byte reads 00h, and pe_grant and pe_deny are low.
- R2: When write-in-progress (status bit 0) is low, a wren_req sets the write-enable latch (status bit 1) and a wrdi_req clears it. While write-in-progress is high, both requests are ignored.
- R3: A wrsr_req while the write-enable latch is 0 changes no status bit and starts no busy interval.
- R4: An accepted status write holds write-in-progress high for exactly WRSR_CYCLES cycles. When that interval ends, the lock bit (bit 7) and the level bits (bits 4..2, level = status[4:2]) take the matching bits of wrsr_data, bits 6 and 5 read 0, and the write-enable latch clears.
- R5: When the lock bit is 1 and wp_n is low, a status write is refused. Bits 7..2 keep their values, no busy interval starts, and the write-enable latch clears. When wp_n is high, the lock bit does not block a status write.
- R6: Block b (pe_addr_hi, 0 to 15) is protected when level is 1..4 and b >= 16 - 2^(level-1), or when level is 5..7. Level 0 protects no block.
- R7: A program or erase request that arrives while write-in-progress is low, with the latch set and an unprotected block, gives pe_grant for one cycle after the request edge. Write-in-progress then stays high until exec_done, and exec_done clears both write-in-progress and the latch.
- R8: A request that arrives while write-in-progress is low but with the latch clear or a protected block gives pe_deny for one cycle and clears the latch.
- R9: A program or erase request that arrives while write-in-progress is high gives pe_deny and leaves the latch unchanged.
- R10: pe_grant and pe_deny are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_req | input | 1 | Set write-enable latch request |
| wrdi_req | input | 1 | Clear write-enable latch request |
| wrsr_req | input | 1 | Status write request |
| wrsr_data | input | 8 | Byte offered by the status write |
| pe_req | input | 1 | Program or erase start request |
| pe_addr_hi | input | BLOCK_W | Block index of the target address |
| exec_busy | input | 1 | Executor busy, ORed into write-in-progress |
| exec_done | input | 1 | Executor finished the granted operation |
| pe_grant | output | 1 | One-cycle grant pulse |
| pe_deny | output | 1 | One-cycle deny pulse |
| status | output | 8 | Current status byte |

## Verification
The bench sweeps all 256 status write values and all 8 levels against all 16 blocks. It computes the expected mask and protected range arithmetically. A design that compared against the wrong boundary block would grant a write into the lowest protected block or deny the block just below it. A design with a wrong write mask would let bits 6, 5 or 1 take the written value.

The bench also checks several cases directly:
- It counts the busy interval cycle by cycle, so an off-by-one timer shows up.
- It checks that a refused or denied request clears the latch, and that a request made during busy leaves it alone. A design that lost the latch on busy denies would fail here.
- It tries the lock with the pin both low and high. A design that ignored the pin would either freeze the byte always or never.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned SR_W     = 8;
  localparam int unsigned BIT_WIP  = 0;
  localparam int unsigned BIT_WEL  = 1;
  localparam int unsigned BIT_LOCK = 7;
  localparam int unsigned LVL_LSB  = 2;
  localparam int unsigned LVL_W    = 3;
  // bits a status write may change: lock and the three level bits
  localparam logic [SR_W-1:0] WR_MASK = 8'h9C;

  typedef enum logic [1:0] {
    PE_NONE  = 2'd0,
    PE_GRANT = 2'd1,
    PE_DENY  = 2'd2
  } pe_verdict_e;
endpackage

// File: rtl/fsr_prot_map.sv
module fsr_prot_map #(
  parameter int unsigned BLOCK_W = 4,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [LVL_W-1:0]   level,
  input  logic [BLOCK_W-1:0] blk,
  output logic               protect
);
  localparam int unsigned NBLK = 1 << BLOCK_W;

  logic [NBLK-1:0] mask;

  // one comparator per block; the level picks how many top blocks are fenced
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_comb begin
      if (level == '0) begin
        mask[g] = 1'b0;
      end else if (int'(level) > int'(BLOCK_W)) begin
        mask[g] = 1'b1;
      end else begin
        mask[g] = (g >= (int'(NBLK) - (1 << (int'(level) - 1))));
      end
    end
  end

  assign protect = mask[blk];
endmodule

// File: rtl/fsr_wr_timer.sv
module fsr_wr_timer #(
  parameter int unsigned CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    en     = 1'b0;
    if (start && !busy_q) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
      en     = 1'b1;
    end else if (busy_q) begin
      en = 1'b1;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fsr_status_guard.sv
module fsr_status_guard
  import fsr_pkg::*;
#(
  parameter int unsigned BLOCK_W     = 4,
  parameter int unsigned WRSR_CYCLES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n,
  input  logic               wren_req,
  input  logic               wrdi_req,
  input  logic               wrsr_req,
  input  logic [SR_W-1:0]    wrsr_data,
  input  logic               pe_req,
  input  logic [BLOCK_W-1:0] pe_addr_hi,
  input  logic               exec_busy,
  input  logic               exec_done,
  output logic               pe_grant,
  output logic               pe_deny,
  output logic [SR_W-1:0]    status
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  // state
  logic [SR_W-1:0] sr_q, sr_d;
  logic [SR_W-1:0] hold_q, hold_d;
  logic            pend_q, pend_d;
  pe_verdict_e     verdict_q, verdict_d;
  logic            sr_en, hold_en, pend_en;

  logic            wr_start, wr_busy, wr_done;
  logic            wip, wel, lock, blk_prot;
  logic [LVL_W-1:0] level;

  assign wel   = sr_q[BIT_WEL];
  assign lock  = sr_q[BIT_LOCK];
  assign level = sr_q[LVL_LSB +: LVL_W];
  assign wip   = wr_busy | pend_q | exec_busy;

  fsr_prot_map #(
    .BLOCK_W (BLOCK_W),
    .LVL_W   (LVL_W)
  ) u_map (
    .level   (level),
    .blk     (pe_addr_hi),
    .protect (blk_prot)
  );

  fsr_wr_timer #(
    .CYCLES (WRSR_CYCLES)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_ns),
    .start (wr_start),
    .busy  (wr_busy),
    .done  (wr_done)
  );

  // next-state
  always_comb begin
    sr_d      = sr_q;
    hold_d    = hold_q;
    pend_d    = pend_q;
    verdict_d = PE_NONE;
    wr_start  = 1'b0;

    // completion events
    if (wr_done) begin
      sr_d             = (sr_q & ~WR_MASK) | (hold_q & WR_MASK);
      sr_d[BIT_WEL]    = 1'b0;
    end
    if (pend_q && exec_done) begin
      pend_d        = 1'b0;
      sr_d[BIT_WEL] = 1'b0;
    end

    // new requests, program/erase first
    if (pe_req) begin
      if (wip) begin
        verdict_d = PE_DENY;
      end else if (!wel || blk_prot) begin
        verdict_d     = PE_DENY;
        sr_d[BIT_WEL] = 1'b0;
      end else begin
        verdict_d = PE_GRANT;
        pend_d    = 1'b1;
      end
    end else if (wrsr_req) begin
      if (!wip && wel) begin
        if (lock && !wp_n) begin
          sr_d[BIT_WEL] = 1'b0;
        end else begin
          wr_start = 1'b1;
          hold_d   = wrsr_data;
        end
      end
    end else if (wrdi_req) begin
      if (!wip) begin
        sr_d[BIT_WEL] = 1'b0;
      end
    end else if (wren_req) begin
      if (!wip) begin
        sr_d[BIT_WEL] = 1'b1;
      end
    end

    sr_d[BIT_WIP] = 1'b0;
    sr_en   = (sr_d != sr_q);
    hold_en = wr_start;
    pend_en = (pend_d != pend_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      verdict_q <= PE_NONE;
    end else begin
      verdict_q <= verdict_d;
    end
  end

  assign pe_grant = (verdict_q == PE_GRANT);
  assign pe_deny  = (verdict_q == PE_DENY);
  assign status   = sr_q | {{(SR_W-1){1'b0}}, wip};
endmodule

// File: rtl/fsr_status_guard_chk.sv
module fsr_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       wrsr_req,
  input logic       pe_req,
  input logic       pe_grant,
  input logic       pe_deny,
  input logic [7:0] status
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe_grant && pe_deny)); // R10

  AST_GRANT_HAD_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    pe_grant |-> ($past(status[1]) && !$past(status[0]))); // R7

  AST_GRANT_SETS_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    pe_grant |-> status[0]); // R7

  AST_NO_WEL_NO_PE: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && !status[1] && !status[0]) |=> (pe_deny && !status[1])); // R8

  AST_BUSY_PE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && status[0]) |=> pe_deny); // R9

  AST_WRSR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_req && !pe_req && !status[1] && !status[0]) |=> $stable(status[7:2])); // R3

  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_req && !pe_req && status[7] && !wp_n && !status[0])
      |=> (status[7] && !status[1] && $stable(status[4:2]))); // R5
endmodule

bind fsr_status_guard fsr_status_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .wp_n     (wp_n),
  .wrsr_req (wrsr_req),
  .pe_req   (pe_req),
  .pe_grant (pe_grant),
  .pe_deny  (pe_deny),
  .status   (status)
);

// File: tb/fsr_status_guard_test.sv
module fsr_status_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLOCK_W    = 4;
  localparam int WCYC       = 6;
  localparam int NBLK       = 1 << BLOCK_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic wren_req = 1'b0, wrdi_req = 1'b0, wrsr_req = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic pe_req = 1'b0;
  logic [BLOCK_W-1:0] pe_addr_hi = '0;
  logic exec_busy = 1'b0, exec_done = 1'b0;
  logic pe_grant, pe_deny;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_status_guard #(.BLOCK_W(BLOCK_W), .WRSR_CYCLES(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .wren_req(wren_req), .wrdi_req(wrdi_req), .wrsr_req(wrsr_req),
    .wrsr_data(wrsr_data), .pe_req(pe_req), .pe_addr_hi(pe_addr_hi),
    .exec_busy(exec_busy), .exec_done(exec_done),
    .pe_grant(pe_grant), .pe_deny(pe_deny), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wren();
    wren_req = 1'b1; tick(); wren_req = 1'b0;
  endtask

  task automatic do_wrdi();
    wrdi_req = 1'b1; tick(); wrdi_req = 1'b0;
  endtask

  // returns number of cycles write-in-progress was seen high
  task automatic do_wrsr(input logic [7:0] d, output int busy_n);
    wrsr_data = d; wrsr_req = 1'b1; tick(); wrsr_req = 1'b0;
    busy_n = 0;
    while (status[0] && busy_n < 100) begin
      busy_n++;
      tick();
    end
  endtask

  function automatic bit exp_prot(input int lvl, input int blk);
    if (lvl == 0) return 1'b0;
    if (lvl > BLOCK_W) return 1'b1;
    return blk >= (NBLK - (1 << (lvl - 1)));
  endfunction

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1
    chk(status == 8'h00, "R1 status after reset", status, 0);
    chk(!pe_grant && !pe_deny, "R1 verdict idle", {pe_grant, pe_deny}, 0);

    // R2
    do_wren();
    chk(status == 8'h02, "R2 wren sets latch", status, 8'h02);
    do_wrdi();
    chk(status == 8'h00, "R2 wrdi clears latch", status, 0);

    // R3
    do_wrsr(8'h9C, n);
    chk(n == 0, "R3 no busy without latch", n, 0);
    chk(status == 8'h00, "R3 status unchanged", status, 0);

    // R4: full sweep of written byte
    for (int d = 0; d < 256; d++) begin
      do_wren();
      do_wrsr(d[7:0], n);
      if (n != WCYC) chk(1'b0, "R4 busy length", n, WCYC);
      else total++;
      if (status != (d[7:0] & 8'h9C)) chk(1'b0, "R4 masked write", status, d & 8'h9C);
      else total++;
    end

    // R5 lock with pin low
    do_wren(); do_wrsr(8'h84, n);
    wp_n = 1'b0;
    do_wren();
    do_wrsr(8'h00, n);
    chk(n == 0, "R5 refused: no busy", n, 0);
    chk(status == 8'h84, "R5 refused: bits kept, latch clear", status, 8'h84);
    // R2 ignore while busy: pin high unlocks
    wp_n = 1'b1;
    do_wren();
    wrsr_data = 8'h00; wrsr_req = 1'b1; tick(); wrsr_req = 1'b0;
    do_wrdi();
    chk(status[1] == 1'b1, "R2 wrdi ignored while busy", status[1], 1);
    while (status[0]) tick();
    chk(status == 8'h00, "R5 pin high allows write", status, 0);

    // R6/R7/R8 sweep levels x blocks
    for (int lvl = 0; lvl < 8; lvl++) begin
      do_wren(); do_wrsr(8'(lvl << 2), n);
      for (int b = 0; b < NBLK; b++) begin
        bit p;
        p = exp_prot(lvl, b);
        do_wren();
        pe_addr_hi = b[BLOCK_W-1:0]; pe_req = 1'b1; tick(); pe_req = 1'b0;
        if (pe_grant && pe_deny) chk(1'b0, "R10 both verdicts", 3, 0);
        if (pe_grant != !p || pe_deny != p)
          chk(1'b0, "R6 protection verdict", {pe_grant, pe_deny}, {!p, p});
        else total++;
        if (p) begin
          if (status[1]) chk(1'b0, "R8 deny clears latch", status, status & 8'hFD);
          else total++;
        end else begin
          tick();
          if (status[1:0] != 2'b11) chk(1'b0, "R7 busy during op", status[1:0], 3);
          else total++;
          exec_done = 1'b1; tick(); exec_done = 1'b0;
          if (status != 8'(lvl << 2)) chk(1'b0, "R7 done clears wip and latch", status, lvl << 2);
          else total++;
        end
      end
    end

    // R8 without latch
    do_wren(); do_wrsr(8'h00, n);
    pe_addr_hi = '0; pe_req = 1'b1; tick(); pe_req = 1'b0;
    chk(pe_deny && !pe_grant, "R8 no latch denied", {pe_grant, pe_deny}, 1);

    // R9 request while busy
    do_wren();
    pe_addr_hi = 4'd3; pe_req = 1'b1; tick(); pe_req = 1'b0;
    chk(pe_grant, "R7 grant pulse", pe_grant, 1);
    tick();
    chk(!pe_grant, "R7 grant lasts one cycle", pe_grant, 0);
    pe_req = 1'b1; tick(); pe_req = 1'b0;
    chk(pe_deny && !pe_grant, "R9 busy denied", {pe_grant, pe_deny}, 1);
    chk(status == 8'h03, "R9 latch kept", status, 8'h03);
    exec_done = 1'b1; tick(); exec_done = 1'b0;
    chk(status == 8'h00, "R7 finished", status, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule